// File: doc/BRIEF.md
# System Clock Ratio Generator

This block sits in the PLL clock domain and produces three clock-enable streams from a single source: a core rate, a bus rate and a peripheral rate. Downstream logic stays on the one PLL clock and advances only in cycles where its enable is high. The ratios come from three select fields of a 32-bit configuration word. The peripheral stream is divided down from the bus stream, not from the source directly.

The source tick is chosen by one bit of the configuration word. When the bit is set, every PLL clock cycle counts as a source tick. When it is clear, only cycles in which the crystal-rate tick input is high count. A new word is latched on a load strobe and held in a staging register. It becomes active only at a cycle where all three dividers wrap together, so no output period already under way is cut short. A synchronous reset clears the active configuration to all zeros.

Top module: `sysclk_ratio_gen`

## Requirements
- R1: The core divisor comes from cfg_word[27:25]. Codes 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16. Codes 5, 6 and 7 give 1.
- R2: The bus divisor comes from cfg_word[22:20]. Codes 0 to 7 give 1, 2, 4, 5, 6, 8, 16 and 32, in that order.
- R3: The peripheral divisor comes from cfg_word[19:18]. Codes 0 to 3 give 1, 2, 4 and 8. It counts bus enables, so the peripheral period is the bus divisor times the peripheral divisor, in source ticks.
- R4: per_en is never high in a cycle where bus_en is low.
- R5: cfg_word[23] = 1 makes every clock cycle a source tick. cfg_word[23] = 0 makes only cycles with xtal_tick high source ticks. No enable is high in a cycle that is not a source tick. Bits outside 27:18 have no effect.
- R6: With divisor 1, an enable is high in every source-tick cycle. In source mode 1 this means it is continuously high.
- R7: A loaded word becomes active after the first cycle in which core_en and per_en are both high. From the next cycle the new ratios count from phase zero. Pulses of the old ratios are never shortened.
- R8: While rst_n is low at a clock edge, the active configuration becomes all zeros: divisors of 1 and the crystal tick as source. Any staged word is discarded.
- R9: A second load before the staged word is applied replaces it. Only the later word takes effect.
- R10: After phase zero, an output with divisor D is high exactly on source ticks D, 2D, 3D and so on, counting from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xtal_tick | input | 1 | Crystal-rate tick, one cycle wide, in the clk domain |
| cfg_load | input | 1 | Strobe that captures cfg_word into the staging register |
| cfg_word | input | 32 | Configuration word holding the select fields and the source bit |
| core_en | output | 1 | Core-rate enable pulse |
| bus_en | output | 1 | Bus-rate enable pulse |
| per_en | output | 1 | Peripheral-rate enable pulse |

## Verification
A wrong divisor decode or a counter off by one changes the spacing of pulses. The effect shows within one period of the affected output, at most 256 source ticks for the peripheral stream. A staging fault that applies a word early shows in the cycle right after the load, as a pulse appearing before the old period ends. A cascade fault shows as per_en rising without bus_en, at the first peripheral pulse. Checking every cycle against a tick-counting model over several hundred cycles per setting catches each of these.

// File: rtl/sysclk_ratio_pkg.sv
// Package: shared field positions, configuration type and divisor decode
// for the system clock ratio generator.
// Assumes divisors never exceed 2**DIV_W - 1.
package sysclk_ratio_pkg;

    localparam int DIV_W    = 6;   // counter / divisor width, holds up to 32
    localparam int CORE_LSB = 25;  // core select field, 3 bits
    localparam int BUS_LSB  = 20;  // bus select field, 3 bits
    localparam int PER_LSB  = 18;  // peripheral select field, 2 bits
    localparam int SRC_BIT  = 23;  // 1: PLL cycles are ticks, 0: crystal ticks

    typedef struct packed {
        logic       src_pll;
        logic [2:0] core_sel;
        logic [2:0] bus_sel;
        logic [1:0] per_sel;
    } ratio_cfg_t;

    // Extract the used fields from a raw configuration word.
    function automatic ratio_cfg_t unpack_cfg(input logic [31:0] w);
        ratio_cfg_t c;
        c.src_pll  = w[SRC_BIT];
        c.core_sel = w[CORE_LSB +: 3];
        c.bus_sel  = w[BUS_LSB +: 3];
        c.per_sel  = w[PER_LSB +: 2];
        return c;
    endfunction

    // Core ratio: powers of two up to 16; reserved codes alias to 1.
    function automatic logic [DIV_W-1:0] core_ratio(input logic [2:0] sel);
        logic [DIV_W-1:0] r;
        if (sel <= 3'd4) r = DIV_W'(1) << sel;
        else             r = DIV_W'(1);
        return r;
    endfunction

    // Bus ratio: power-of-two table with 5 and 6 mixed in.
    function automatic logic [DIV_W-1:0] bus_ratio(input logic [2:0] sel);
        logic [DIV_W-1:0] r;
        case (sel)
            3'd0:    r = DIV_W'(1);
            3'd1:    r = DIV_W'(2);
            3'd2:    r = DIV_W'(4);
            3'd3:    r = DIV_W'(5);
            3'd4:    r = DIV_W'(6);
            3'd5:    r = DIV_W'(8);
            3'd6:    r = DIV_W'(16);
            default: r = DIV_W'(32);
        endcase
        return r;
    endfunction

    // Peripheral ratio: plain power of two.
    function automatic logic [DIV_W-1:0] per_ratio(input logic [1:0] sel);
        return DIV_W'(1) << sel;
    endfunction

endpackage

// File: rtl/sysclk_div_counter.sv
// Module: one modulo-N tick counter.
// Counts cycles in which adv is high and flags the last one of each period.
// Assumes div is at least 1 and changes only in a cycle right after a wrap.
module sysclk_div_counter #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             term
);

    logic [DIV_W-1:0] cnt;

    // Terminal flag: this advancing cycle closes the current period.
    assign term = adv && (cnt == div - DIV_W'(1));

    // Phase counter: wrap to zero at the end of a period, else step on adv.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (term)  cnt <= '0;
        else if (adv)   cnt <= cnt + DIV_W'(1);
    end

    // R6: with divisor 1 every advancing cycle produces a pulse.
    assert_div1_every_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && div == DIV_W'(1)) |-> term);

    // R5: no pulse is produced in a cycle without a source tick.
    assert_pulse_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |-> !term);

endmodule

// File: rtl/sysclk_cfg_stage.sv
// Module: configuration staging.
// Captures the word on a load strobe and moves it to the active set
// only in a cycle where all dividers end their periods together.
// Assumes boundary is high only when every counter is terminal.
module sysclk_cfg_stage
    import sysclk_ratio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] word,
    input  logic        boundary,
    output ratio_cfg_t  active
);

    ratio_cfg_t staged;
    logic       pending;

    // Staging register: the latest load wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    staged <= '0;
        else if (load) staged <= unpack_cfg(word);
    end

    // Pending flag: set by a load, cleared when applied (a load in the
    // apply cycle keeps it set so the newer word is applied later).
    always_ff @(posedge clk) begin
        if (!rst_n)                   pending <= 1'b0;
        else if (load)                pending <= 1'b1;
        else if (boundary && pending) pending <= 1'b0;
    end

    // Active set: updated only at a common period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active <= '0;
        else if (boundary && pending) active <= staged;
    end

    // R7: the active set changes only after a boundary with a word waiting.
    assert_apply_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active != $past(active)) |-> $past(boundary && pending));

    // R8: the first cycle out of reset sees the all-zero configuration.
    assert_reset_cfg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (active == '0 && !pending));

endmodule

// File: rtl/sysclk_ratio_gen.sv
// Module: top of the system clock ratio generator.
// Derives core, bus and peripheral enable pulses from one source tick.
// The peripheral counter advances on bus pulses (cascade).
// Assumes xtal_tick is already synchronous to clk.
module sysclk_ratio_gen
    import sysclk_ratio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xtal_tick,
    input  logic        cfg_load,
    input  logic [31:0] cfg_word,
    output logic        core_en,
    output logic        bus_en,
    output logic        per_en
);

    ratio_cfg_t       active;
    logic             src_tick;
    logic             boundary;
    logic [DIV_W-1:0] core_div, bus_div, per_div;

    // Source tick selection from the active configuration.
    assign src_tick = active.src_pll ? 1'b1 : xtal_tick;

    // Divisor decode of the active select fields.
    assign core_div = core_ratio(active.core_sel);
    assign bus_div  = bus_ratio(active.bus_sel);
    assign per_div  = per_ratio(active.per_sel);

    // Common boundary: core and cascaded peripheral both end here.
    assign boundary = core_en && per_en;

    sysclk_cfg_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .word     (cfg_word),
        .boundary (boundary),
        .active   (active)
    );

    sysclk_div_counter #(.DIV_W(DIV_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (src_tick),
        .div   (core_div),
        .term  (core_en)
    );

    sysclk_div_counter #(.DIV_W(DIV_W)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (src_tick),
        .div   (bus_div),
        .term  (bus_en)
    );

    sysclk_div_counter #(.DIV_W(DIV_W)) u_per (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bus_en),
        .div   (per_div),
        .term  (per_en)
    );

    // R4: peripheral pulses fall only on bus pulses.
    assert_per_within_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> bus_en);

    // R5: in crystal mode, no enable without a crystal tick.
    assert_xtal_gates_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active.src_pll && !xtal_tick) |-> (!core_en && !bus_en && !per_en));

endmodule

// File: tb/tb_sysclk_ratio_gen.sv
module tb_sysclk_ratio_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b1;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        core_en, bus_en, per_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sysclk_ratio_gen dut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .cfg_load(cfg_load),
        .cfg_word(cfg_word), .core_en(core_en), .bus_en(bus_en), .per_en(per_en)
    );

    localparam int NV = 10;
    localparam int VC  [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 1, 4};
    localparam int VB  [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 3, 1};
    localparam int VP  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 1, 0};
    localparam int VS  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
    localparam int EDC [NV] = '{1, 2, 4, 8, 16, 1, 1, 1, 2, 16};
    localparam int EDB [NV] = '{1, 2, 4, 5, 6, 8, 16, 32, 5, 2};
    localparam int EDP [NV] = '{1, 2, 4, 8, 1, 2, 4, 8, 2, 1};

    function automatic logic [31:0] mk(input int c, input int b, input int p, input int s);
        logic [31:0] w;
        w = 32'hF100_5A5A;  // bits outside the fields, must be ignored
        w[27:25] = 3'(c);
        w[22:20] = 3'(b);
        w[19:18] = 2'(p);
        w[23]    = s[0];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_load = 1'b0; xtal_tick = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Load a word from the divide-by-1 reset state; returns in cycle 0 of the new set.
    task automatic load_from_reset(input logic [31:0] w);
        cfg_word = w; cfg_load = 1'b1;
        @(posedge clk); #1 cfg_load = 1'b0;
        @(posedge clk); #1;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R8 R6: reset state gives divide by 1 on every output from crystal ticks.
        #1;
        check(core_en && bus_en && per_en, "R8 reset div1 all high", {core_en, bus_en, per_en}, 7);
        // R5: reset source is the crystal tick; no tick means no enable.
        xtal_tick = 1'b0; #1;
        check(!core_en && !bus_en && !per_en, "R5 reset crystal source", {core_en, bus_en, per_en}, 0);
        xtal_tick = 1'b1;

        // Table walk: R1 R2 R3 R4 R5 R6 R10 against a tick-counting model.
        for (int v = 0; v < NV; v++) begin
            int mc, mb, mp, m4, t;
            do_reset();
            load_from_reset(mk(VC[v], VB[v], VP[v], VS[v]));
            mc = 0; mb = 0; mp = 0; m4 = 0; t = 0;
            for (int i = 0; i < 600; i++) begin
                bit tk;
                xtal_tick = ((i % 3) != 1);
                tk = (VS[v] == 1) ? 1'b1 : xtal_tick;
                #1;
                if (tk) t++;
                if (core_en != (tk && (t % EDC[v] == 0))) mc++;
                if (bus_en  != (tk && (t % EDB[v] == 0))) mb++;
                if (per_en  != (tk && (t % (EDB[v] * EDP[v]) == 0))) mp++;
                if (per_en && !bus_en) m4++;
                @(posedge clk); #1;
            end
            check(mc == 0, $sformatf("R1 R10 core vector %0d", v), mc, 0);
            check(mb == 0, $sformatf("R2 R10 bus vector %0d", v), mb, 0);
            check(mp == 0, $sformatf("R3 per vector %0d", v), mp, 0);
            check(m4 == 0, $sformatf("R4 per outside bus vector %0d", v), m4, 0);
        end

        // R7 R9: core div 4 active; load div 16 then div 2 mid-period.
        begin
            int bad;
            bit exp;
            do_reset();
            load_from_reset(mk(2, 0, 0, 1));
            bad = 0;
            for (int i = 0; i < 12; i++) begin
                cfg_load = (i == 0) || (i == 1);
                cfg_word = (i == 0) ? mk(4, 0, 0, 1) : mk(1, 0, 0, 1);
                #1;
                exp = (i == 3) || (i == 5) || (i == 7) || (i == 9) || (i == 11);
                if (core_en != exp) begin
                    bad++;
                    $display("FAIL R7 cycle %0d: actual %0d expected %0d", i, core_en, exp);
                end
                @(posedge clk); #1;
            end
            cfg_load = 1'b0;
            check(bad == 0, "R7 apply at common boundary, old period kept", bad, 0);
            check(bad == 0, "R9 later load replaces staged word", bad, 0);
        end

        // R5: a word with the used fields at zero but junk elsewhere keeps div 1.
        begin
            int bad;
            do_reset();
            load_from_reset(mk(0, 0, 0, 1));
            bad = 0;
            for (int i = 0; i < 20; i++) begin
                xtal_tick = 1'b0; #1;
                if (!(core_en && bus_en && per_en)) bad++;
                @(posedge clk); #1;
            end
            check(bad == 0, "R5 R6 pll source ignores crystal, junk bits ignored", bad, 0);
        end

        // R8: reset in the middle of a slow setting returns to divide by 1.
        do_reset();
        load_from_reset(mk(4, 7, 3, 1));
        repeat (7) @(posedge clk);
        do_reset();
        xtal_tick = 1'b1; #1;
        check(core_en && bus_en && per_en, "R8 reset mid-period", {core_en, bus_en, per_en}, 7);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule